// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates thirteen interrupt sources for an 8-bit CPU. Five sources come from neighbouring logic as plain level requests: two legacy external lines, two timers and a serial engine. The other eight are port pins with edge detection. Each port pin has a programmable active polarity. When its source is enabled, an active edge sets a sticky request flag that only software can clear.

Every source has an enable bit and a one-bit level. A global enable gates all of them. Once per machine cycle, on the tick strobe, the controller looks at the eligible requests. It prefers the high level, then breaks ties with a fixed order that mixes external, serial and timer sources. It then issues one vector address to the CPU.

A two-entry in-service record holds the levels now being served. A high-level request can interrupt a low-level routine. A request at the same or a lower level waits. A return pulse retires the most recently entered level.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset `vec_valid_o` is 0, `vec_addr_o` is 0, `in_svc_o` is 00 and `flag_o` is all zero.
- R2: While `glb_en_i` is 0, no vector is issued, whatever the individual enables and requests.
- R3: A source whose bit in `src_en_i` is 0 is never granted. Bit map: 0 INT0, 1 INT1, 2 timer 0, 3 timer 1, 4 serial, 5..12 port pins 0..7.
- R4: Among eligible sources, a source with its `src_lvl_i` bit at 1 (high) beats any source at 0 (low), whatever the tie-break order.
- R5: Within one level, the winner is the first in this order: INT0, serial, pin 3, timer 0, pin 4, INT1, pin 0, pin 5, timer 1, pin 1, pin 6, pin 2, pin 7.
- R6: The vector addresses are: INT0 0003h, timer 0 000Bh, INT1 0013h, timer 1 001Bh, serial 002Bh, and pin n (n = 0..7) 003Bh + 8·n.
- R7: A pin with `pol_i` bit 1 requests on a rising edge. A pin with `pol_i` bit 0 requests on a falling edge. The opposite edge sets nothing.
- R8: A port flag is set only when its source enable is 1. It stays set until its `clr_i` bit is pulsed, and then it reads 0.
- R9: Requests are sampled only on cycles with `tick_i` high. `vec_valid_o` is a single-cycle pulse in the cycle after that tick, so at most one vector is issued per tick.
- R10: A high request is granted while only a low level is in service. No request is granted while the high level is in service. A low request is granted only when nothing is in service.
- R11: A `reti_i` pulse clears the high in-service bit if it is set, and otherwise clears the low bit. `in_svc_o` bit 1 marks high in service and bit 0 marks low in service.
- R12: A port flag becomes visible on the third rising clock edge after the pin takes its active value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Machine-cycle strobe; arbitration happens on it |
| glb_en_i | input | 1 | Global enable |
| src_en_i | input | 13 | Per-source enable |
| src_lvl_i | input | 13 | Per-source level, 1 = high |
| periph_req_i | input | 5 | Level requests: INT0, INT1, timer 0, timer 1, serial |
| pin_i | input | 8 | Asynchronous port interrupt pins |
| pol_i | input | 8 | Pin polarity, 1 = active high |
| clr_i | input | 8 | Software clear of port flags |
| reti_i | input | 1 | Return-from-interrupt pulse |
| flag_o | output | 8 | Port request flags |
| vec_valid_o | output | 1 | Vector issued this cycle |
| vec_addr_o | output | 16 | Vector address of the last grant |
| in_svc_o | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
A grant lands one edge after the tick that sampled it. The bench therefore raises `tick_i` at a falling edge and reads `vec_valid_o`, `vec_addr_o` and `in_svc_o` at the next falling edge. A pin change reaches `flag_o` only on the third rising edge: two synchroniser stages plus the flag register. So every flag check waits exactly three rising edges and samples on the falling edge after them. Return and clear pulses act on the next edge and are checked one falling edge later.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NSRC  = 13;
  localparam int NPER  = 5;
  localparam int NPIN  = 8;
  localparam int IDW   = $clog2(NSRC);
  localparam int VEC_W = 16;

  // natural tie-break order within a level: rank -> source id
  function automatic logic [IDW-1:0] rank_id(input int r);
    case (r)
      0:  return IDW'(0);
      1:  return IDW'(4);
      2:  return IDW'(8);
      3:  return IDW'(2);
      4:  return IDW'(9);
      5:  return IDW'(1);
      6:  return IDW'(5);
      7:  return IDW'(10);
      8:  return IDW'(3);
      9:  return IDW'(6);
      10: return IDW'(11);
      11: return IDW'(7);
      default: return IDW'(12);
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDW-1:0] id);
    case (id)
      IDW'(0): return VEC_W'('h03);
      IDW'(1): return VEC_W'('h13);
      IDW'(2): return VEC_W'('h0B);
      IDW'(3): return VEC_W'('h1B);
      IDW'(4): return VEC_W'('h2B);
      default: return VEC_W'('h3B) + ((VEC_W'(id) - VEC_W'(NPER)) << 3);
    endcase
  endfunction
endpackage

// File: rtl/irq_pin_flags.sv
module irq_pin_flags #(
  parameter int NPIN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] en_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] flag_o
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic s1_q, s2_q, act_q, flag_q;
    logic act, edge_hit;
    assign act      = ~(s2_q ^ pol_i[g]);
    assign edge_hit = act & ~act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        act_q  <= 1'b1; // no edge seen until the pin first goes inactive
        flag_q <= 1'b0;
      end else begin
        s1_q   <= pin_i[g];
        s2_q   <= s1_q;
        act_q  <= act;
        flag_q <= (flag_q & ~clr_i[g]) | (edge_hit & en_i[g]);
      end
    end
    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_nest_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] lvl_i,
  input  logic            glb_en_i,
  output logic            hi_hit_o,
  output logic [IDW-1:0]  hi_id_o,
  output logic            lo_hit_o,
  output logic [IDW-1:0]  lo_id_o
);
  logic [NSRC-1:0] elig;
  assign elig = pend_i & en_i & {NSRC{glb_en_i}};

  always_comb begin
    logic [IDW-1:0] id;
    hi_hit_o = 1'b0;
    lo_hit_o = 1'b0;
    hi_id_o  = '0;
    lo_id_o  = '0;
    for (int r = 0; r < NSRC; r++) begin
      id = rank_id(r);
      if (elig[id] && lvl_i[id] && !hi_hit_o) begin
        hi_hit_o = 1'b1;
        hi_id_o  = id;
      end
      if (elig[id] && !lvl_i[id] && !lo_hit_o) begin
        lo_hit_o = 1'b1;
        lo_id_o  = id;
      end
    end
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       reti_i,
  input  logic       hi_hit_i,
  input  logic       lo_hit_i,
  output logic       gnt_o,
  output logic       gnt_hi_o,
  output logic [1:0] act_o
);
  logic [1:0] act_q, pop, push;
  logic       ok_hi, ok_lo;

  assign ok_hi    = hi_hit_i & ~act_q[1];
  assign ok_lo    = lo_hit_i & (act_q == 2'b00);
  assign gnt_o    = tick_i & (ok_hi | ok_lo);
  assign gnt_hi_o = ok_hi;
  assign push     = gnt_o ? (ok_hi ? 2'b10 : 2'b01) : 2'b00;
  assign pop      = !reti_i ? 2'b00 : (act_q[1] ? 2'b10 : 2'b01);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 2'b00;
    else         act_q <= (act_q & ~pop) | push;
  end
  assign act_o = act_q;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              glb_en_i,
  input  logic [NSRC-1:0]   src_en_i,
  input  logic [NSRC-1:0]   src_lvl_i,
  input  logic [NPER-1:0]   periph_req_i,
  input  logic [NPIN-1:0]   pin_i,
  input  logic [NPIN-1:0]   pol_i,
  input  logic [NPIN-1:0]   clr_i,
  input  logic              reti_i,
  output logic [NPIN-1:0]   flag_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_addr_o,
  output logic [1:0]        in_svc_o
);
  logic           hi_hit, lo_hit, gnt, gnt_hi;
  logic [IDW-1:0] hi_id, lo_id;

  irq_pin_flags #(.NPIN(NPIN)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .pol_i  (pol_i),
    .en_i   (src_en_i[NSRC-1:NPER]),
    .clr_i  (clr_i),
    .flag_o (flag_o)
  );

  irq_pick u_pick (
    .pend_i   ({flag_o, periph_req_i}),
    .en_i     (src_en_i),
    .lvl_i    (src_lvl_i),
    .glb_en_i (glb_en_i),
    .hi_hit_o (hi_hit),
    .hi_id_o  (hi_id),
    .lo_hit_o (lo_hit),
    .lo_id_o  (lo_id)
  );

  irq_level_stack u_stack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .reti_i   (reti_i),
    .hi_hit_i (hi_hit),
    .lo_hit_i (lo_hit),
    .gnt_o    (gnt),
    .gnt_hi_o (gnt_hi),
    .act_o    (in_svc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      vec_addr_o  <= '0;
    end else begin
      vec_valid_o <= gnt;
      if (gnt) vec_addr_o <= vec_of(gnt_hi ? hi_id : lo_id);
    end
  end
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        glb_en_i,
  input logic        reti_i,
  input logic [7:0]  clr_i,
  input logic [7:0]  flag_o,
  input logic        vec_valid_o,
  input logic [15:0] vec_addr_o,
  input logic [1:0]  in_svc_o
);
  p_tick_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(tick_i));

  p_glb_block_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!glb_en_i) |-> !vec_valid_o);

  p_lo_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_svc_o[0]) |-> $past(in_svc_o) == 2'b00);

  p_hi_grant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_svc_o[1]) |-> vec_valid_o);

  p_svc_marked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> in_svc_o != 2'b00);

  p_vec_shape_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_addr_o & 16'hFF87) == 16'h0003);

  p_flag_sw_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flag_o) & ~flag_o & ~$past(clr_i)) == 8'h00);

  p_reti_pop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !tick_i && in_svc_o == 2'b11) |=> in_svc_o == 2'b01);
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .glb_en_i    (glb_en_i),
  .reti_i      (reti_i),
  .clr_i       (clr_i),
  .flag_o      (flag_o),
  .vec_valid_o (vec_valid_o),
  .vec_addr_o  (vec_addr_o),
  .in_svc_o    (in_svc_o)
);

// File: tb/irq_nest_ctrl_tb.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb;
  logic        clk = 0, rst_n = 0;
  logic        tick = 0, glb = 0, reti = 0;
  logic [12:0] en = '0, lvl = '0;
  logic [4:0]  preq = '0;
  logic [7:0]  pin = '0, pol = 8'hFF, clr = '0;
  logic [7:0]  flag;
  logic        vv;
  logic [15:0] va;
  logic [1:0]  svc;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_nest_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .glb_en_i(glb),
    .src_en_i(en), .src_lvl_i(lvl), .periph_req_i(preq), .pin_i(pin),
    .pol_i(pol), .clr_i(clr), .reti_i(reti), .flag_o(flag),
    .vec_valid_o(vv), .vec_addr_o(va), .in_svc_o(svc)
  );

  int order [13] = '{0, 4, 8, 2, 9, 1, 5, 10, 3, 6, 11, 7, 12};

  function automatic logic [15:0] ref_vec(int id);
    case (id)
      0: return 16'h0003;  1: return 16'h0013;  2: return 16'h000B;
      3: return 16'h001B;  4: return 16'h002B;  5: return 16'h003B;
      6: return 16'h0043;  7: return 16'h004B;  8: return 16'h0053;
      9: return 16'h005B; 10: return 16'h0063; 11: return 16'h006B;
      default: return 16'h0073;
    endcase
  endfunction

  // expected grant with nothing in service
  function automatic void ref_pick(input logic [12:0] pend, input logic [12:0] e,
                                   input logic [12:0] l, input logic g,
                                   output logic v, output logic [15:0] a);
    v = 0; a = 0;
    for (int pass = 1; pass >= 0; pass--)
      for (int r = 0; r < 13; r++)
        if (!v && g && pend[order[r]] && e[order[r]] && l[order[r]] == pass[0]) begin
          v = 1; a = ref_vec(order[r]);
        end
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic pulse_reti();
    reti = 1; @(negedge clk); reti = 0;
  endtask

  task automatic wait_flag();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ev; logic [15:0] ea;
    void'($urandom(32'h1234_5678));
    do_reset();
    // R1 reset state
    chk(vv == 0 && svc == 0 && flag == 0 && va == 0, "R1 reset", {vv, svc, flag, va}, 0);

    // R2 global disable
    en = '1; lvl = '0; preq = 5'h1F;
    pulse_tick();
    chk(vv == 0, "R2 glb off", vv, 0);

    // R9 no tick -> no vector
    glb = 1;
    repeat (4) @(negedge clk);
    chk(vv == 0 && svc == 0, "R9 no tick", {vv, svc}, 0);

    // R3 disabled source skipped: only INT0 enabled off, INT0 & serial requesting
    preq = 5'b10001; en = 13'h1FFE;
    pulse_tick();
    chk(vv == 1 && va == 16'h002B, "R3 en skip", va, 16'h002B);
    @(negedge clk);
    chk(vv == 0, "R9 single pulse", vv, 0);
    pulse_reti(); preq = 0; en = '1;

    // R10/R11 nesting: T0 low, pin7 and INT1 high
    lvl = '0; lvl[12] = 1; lvl[1] = 1;
    preq = 5'b00100;
    pulse_tick();
    chk(vv && va == 16'h000B && svc == 2'b01, "R10 low grant", {va, svc}, {16'h000B, 2'b01});
    pulse_tick();
    chk(!vv && svc == 2'b01, "R10 same level waits", {vv, svc}, 2'b01);
    pin[7] = 1; wait_flag();
    chk(flag[7] == 1, "R12 flag latency", flag, 8'h80);
    pulse_tick();
    chk(vv && va == 16'h0073 && svc == 2'b11, "R10 high preempts", {va, svc}, {16'h0073, 2'b11});
    preq[1] = 1;
    pulse_tick();
    chk(!vv && svc == 2'b11, "R10 high blocked", {vv, svc}, 2'b11);
    pulse_reti();
    chk(svc == 2'b01, "R11 pop high", svc, 2'b01);
    pulse_tick();
    chk(vv && va == 16'h0013 && svc == 2'b11, "R5 high order", {va, svc}, {16'h0013, 2'b11});
    pulse_reti(); pulse_reti();
    chk(svc == 2'b00, "R11 pop both", svc, 0);
    chk(flag[7] == 1, "R8 flag held", flag, 8'h80);
    clr = 8'hFF; @(negedge clk); clr = 0;
    chk(flag == 0, "R8 clear", flag, 0);
    preq = 0; pin = 0;

    // random arbitration trials
    for (int t = 0; t < 80; t++) begin
      logic [7:0] pm; logic [4:0] pr;
      en = 13'($urandom); lvl = 13'($urandom); glb = ($urandom % 4) != 0;
      pm = 8'($urandom); pr = 5'($urandom);
      @(negedge clk);
      pin = pm; wait_flag();
      chk(flag == (pm & en[12:5]), "R8 enabled set", flag, pm & en[12:5]);
      pin = 0; preq = pr;
      ref_pick({pm & en[12:5], pr}, en, lvl, glb, ev, ea);
      pulse_tick();
      chk(vv == ev && (!ev || va == ea), "R4 R5 R6 pick", {vv, va}, {ev, ea});
      preq = 0; pulse_reti(); pulse_reti();
      clr = 8'hFF; @(negedge clk); clr = 0;
      chk(svc == 0 && flag == 0, "R11 cleanup", {svc, flag}, 0);
      repeat (2) @(negedge clk);
    end

    // R6 each vector alone, low level
    glb = 1; en = '1; lvl = '0;
    for (int i = 0; i < 5; i++) begin
      preq = 5'(1 << i);
      pulse_tick();
      chk(vv && va == ref_vec(i), "R6 periph vector", va, ref_vec(i));
      preq = 0; pulse_reti();
    end

    // R7 falling-edge polarity
    pol = 8'hFE; pin = 8'h01; en = '1;
    do_reset();
    repeat (4) @(negedge clk);
    chk(flag == 0, "R7 no spurious", flag, 0);
    pin[0] = 0; wait_flag();
    chk(flag == 8'h01, "R7 falling edge", flag, 8'h01);
    pin[1] = 1; wait_flag(); pin[1] = 0; wait_flag();
    chk(flag == 8'h03, "R7 rising sets, falling ignored", flag, 8'h03);
    pulse_tick();
    chk(vv && va == 16'h003B, "R6 pin0 vector", va, 16'h003B);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule